// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write SRAM

A single-port synchronous static memory. Every access is taken in on the rising clock edge. Input registers capture the address, the write data and the write qualifiers. The array is read or written on the following edge. Read data then passes through an output register, so a read reaches the pins two edges after it was sampled. Writes need no externally shaped pulse. The registered request commits to the array on the next edge.

Writes can target any subset of the four byte lanes. A global-write input stores the whole word whatever the lane enables say. The output side has an asynchronous output enable and a sleep input. Data comes out zeroed whenever it is not driven, together with a valid flag. A deselected or write cycle empties exactly one output slot. Back-to-back reads therefore stream continuously. The array depth is set by `ADDR_W`: the default is 10, and 16 gives 65536 words.

Top module: `sram_pipe_top`

## Requirements
- R1: The array holds 2**ADDR_W words of 32 bits. Byte lane i occupies bits 8i+7..8i, and every address from 0 to 2**ADDR_W-1 stores and returns its own word.
- R2: A read (cs=1, we=0, gw=0, sleep=0) sampled at edge n shows its word on rdata with rdata_valid=1 after edge n+2, for one clock cycle. Reads on consecutive cycles give valid on consecutive cycles.
- R3: With cs=1, we=1 and gw=0, lane i is written only when be[i]=1, and the other lanes keep their contents. With be=0 nothing changes.
- R4: With cs=1 and gw=1, all four lanes are written, whatever be and we are.
- R5: With cs=1, we=1 and be=4'b1111, the full word is written.
- R6: A cycle with cs=0 or a write cycle yields rdata_valid=0 in exactly its own output slot, two edges after sampling. Neighbouring read slots are unaffected.
- R7: oe acts combinationally. oe=0 forces rdata_valid=0 in the same cycle. Reads already in flight still advance, so a read whose slot falls while oe=1 is delivered normally.
- R8: While sleep=1, requests are ignored and rdata_valid=0. Words written before sleep read back unchanged afterwards.
- R9: A read on the cycle right after a write to the same address returns the newly written data.
- R10: After reset, rdata_valid=0 and rdata=0.
- R11: rdata is all zeros whenever rdata_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Chip select, registered |
| we | input | 1 | Write enable for the lane-qualified write |
| gw | input | 1 | Global write of all lanes |
| be | input | 4 | Per-lane write enables |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| oe | input | 1 | Asynchronous output enable |
| sleep | input | 1 | Sleep: ignore requests, stop driving |
| rdata | output | 32 | Read data, zero when not driven |
| rdata_valid | output | 1 | rdata carries a read result |

## Verification
The bench targets the following corner cases:

- **Partial-lane writes over an earlier full word.** A design that ignored be, or let a global write depend on be, would return wrong bytes.
- **A read issued on the cycle right after a write to the same address.** This exposes a stale array read.
- **A deselect cycle placed between streaming reads.** The deselect must blank exactly one slot; an output stage that held valid, or dropped it for two cycles, fails here.
- **Output-enable toggling and sleep periods with write attempts.** These show whether oe stalls the pipeline or whether sleep lets a write reach the array.

// File: rtl/sram_pkg.sv
package sram_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              gw,
  input  logic [LANES-1:0]  be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              sleep,
  output logic              rd_q,
  output logic [LANES-1:0]  wmask_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  op_e              op_d;
  logic             rd_d;
  logic [LANES-1:0] wmask_d;
  logic             cap_en;

  always_comb begin
    op_d = OP_IDLE;
    if (cs && !sleep) begin
      if (gw || we) op_d = OP_WRITE;
      else          op_d = OP_READ;
    end
    wmask_d = '0;
    if (op_d == OP_WRITE) wmask_d = gw ? {LANES{1'b1}} : be;
    rd_d   = (op_d == OP_READ);
    cap_en = (op_d != OP_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      wmask_q <= '0;
    end else begin
      rd_q    <= rd_d;
      wmask_q <= wmask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end
endmodule

// File: rtl/sram_lane.sv
module sram_lane #(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wbyte;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rbyte_q <= mem[addr];
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_q,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              oe,
  input  logic              sleep,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid
);
  logic              arr_v_q;
  logic              out_v_q;
  logic [DATA_W-1:0] out_q;
  logic              drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_v_q <= 1'b0;
      out_v_q <= 1'b0;
    end else begin
      arr_v_q <= rd_q;
      out_v_q <= arr_v_q;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_v_q) out_q <= arr_data;
  end

  always_comb begin
    drive       = out_v_q && oe && !sleep;
    rdata_valid = drive;
    rdata       = drive ? out_q : '0;
  end
endmodule

// File: rtl/sram_pipe_top.sv
module sram_pipe_top
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              we,
  input  logic              gw,
  input  logic [3:0]        be,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              oe,
  input  logic              sleep,
  output logic [31:0]       rdata,
  output logic              rdata_valid
);
  logic              rst_meta_q;
  logic              rst_core_n;
  logic              rd_q;
  logic [LANES-1:0]  wmask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  sram_in_reg #(.ADDR_W(ADDR_W)) u_in (
    .clk(clk), .rst_n(rst_core_n), .cs(cs), .we(we), .gw(gw), .be(be),
    .addr(addr), .wdata(wdata), .sleep(sleep),
    .rd_q(rd_q), .wmask_q(wmask_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    sram_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_lane (
      .clk    (clk),
      .wr_en  (wmask_q[i]),
      .rd_en  (rd_q),
      .addr   (addr_q),
      .wbyte  (wdata_q[i*BYTE_W +: BYTE_W]),
      .rbyte_q(arr_data[i*BYTE_W +: BYTE_W])
    );
  end

  sram_out_stage u_out (
    .clk(clk), .rst_n(rst_core_n), .rd_q(rd_q), .arr_data(arr_data),
    .oe(oe), .sleep(sleep), .rdata(rdata), .rdata_valid(rdata_valid)
  );
endmodule

// File: rtl/sram_pipe_chk.sv
module sram_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs,
  input logic        we,
  input logic        gw,
  input logic        oe,
  input logic        sleep,
  input logic [31:0] rdata,
  input logic        rdata_valid
);
  logic acc_q1, acc_q2, acc_q3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q1 <= 1'b0;
      acc_q2 <= 1'b0;
      acc_q3 <= 1'b0;
    end else begin
      acc_q1 <= cs && !we && !gw && !sleep;
      acc_q2 <= acc_q1;
      acc_q3 <= acc_q2;
    end
  end

  p_read_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q3 && oe && !sleep) |-> rdata_valid);

  p_empty_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_q3 |-> !rdata_valid);

  p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rdata_valid);

  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_valid);

  p_zero_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_valid |-> (rdata == 32'd0));
endmodule

bind sram_pipe_top sram_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .gw(gw), .oe(oe),
  .sleep(sleep), .rdata(rdata), .rdata_valid(rdata_valid)
);

// File: tb/tb_sram_pipe_top.sv
module tb_sram_pipe_top;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cs, we, gw, oe, sleep;
  logic [3:0]        be;
  logic [ADDR_W-1:0] addr;
  logic [31:0]       wdata;
  logic [31:0]       rdata;
  logic              rdata_valid;

  sram_pipe_top #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .gw(gw), .be(be),
    .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
    .rdata(rdata), .rdata_valid(rdata_valid)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    logic        v;
    logic [31:0] d;
    string       tag;
  } item_t;

  item_t       sb[$];
  logic [31:0] model [int];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic c, input logic w, input logic g,
                       input logic [3:0] b, input int a, input logic [31:0] d,
                       input logic o, input logic s);
    item_t it;
    @(negedge clk);
    cs = c; we = w; gw = g; be = b; addr = a[ADDR_W-1:0]; wdata = d; oe = o; sleep = s;
    it.due = cyc + 3; it.tag = tag; it.v = 1'b0; it.d = '0;
    if (c && !s && (g || w)) begin
      logic [31:0] old;
      logic [3:0]  m;
      old = model.exists(a) ? model[a] : 32'd0;
      m   = g ? 4'hF : b;
      for (int i = 0; i < 4; i++) if (m[i]) old[i*8 +: 8] = d[i*8 +: 8];
      model[a] = old;
    end else if (c && !s) begin
      it.v = 1'b1;
      it.d = model.exists(a) ? model[a] : 32'd0;
    end
    sb.push_back(it);
  endtask

  task automatic rd(input string tag, input int a, input logic o = 1'b1);
    drive(tag, 1, 0, 0, 4'h0, a, 32'd0, o, 0);
  endtask

  task automatic idle(input string tag, input logic o = 1'b1, input logic s = 1'b0);
    drive(tag, 0, 0, 0, 4'h0, 0, 32'd0, o, s);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      cyc++;
      #5;
      while (sb.size() > 0 && sb[0].due == cyc) begin
        item_t it;
        logic  ev;
        it = sb.pop_front();
        ev = it.v && oe && !sleep;
        check({it.tag, " valid"}, {31'd0, rdata_valid}, {31'd0, ev});
        if (ev) check({it.tag, " data"}, rdata, it.d);
        else    check({it.tag, " R11 zero"}, rdata, 32'd0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 0; cs = 0; we = 0; gw = 0; be = 0; addr = '0; wdata = '0; oe = 1; sleep = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    repeat (4) @(posedge clk);
    #5;
    check("R10 reset valid", {31'd0, rdata_valid}, 32'd0);
    check("R10 reset data", rdata, 32'd0);

    // R4: global write ignores be and we
    drive("R4 gw write", 1, 0, 1, 4'h0, 5, 32'hA5A5_0001, 1, 0);
    rd("R4 read", 5);
    // R3: partial lanes 0 and 2
    drive("R3 lane write", 1, 1, 0, 4'b0101, 5, 32'h1122_3344, 1, 0);
    rd("R3 read", 5);
    // R5 full word then R9 read on next cycle
    drive("R5 full write", 1, 1, 0, 4'hF, 9, 32'hDEAD_BEEF, 1, 0);
    rd("R9 rd after wr", 9);
    // R3: empty be changes nothing
    drive("R3 empty be", 1, 1, 0, 4'h0, 9, 32'h0000_0000, 1, 0);
    rd("R3 empty be read", 9);
    // R2 back-to-back, R6 single deselect gap
    rd("R2 stream a", 5);
    rd("R2 stream b", 9);
    rd("R2 stream c", 5);
    idle("R6 deselect");
    rd("R6 after gap", 9);
    drive("R6 write slot", 1, 1, 0, 4'b1000, 9, 32'h7700_0000, 1, 0);
    rd("R6 after write", 9);
    // R1 boundary addresses
    drive("R1 top write", 1, 0, 1, 4'h3, DEPTH-1, 32'hCAFE_F00D, 1, 0);
    drive("R1 zero write", 1, 0, 1, 4'h0, 0, 32'h0BAD_1DEA, 1, 0);
    rd("R1 top read", DEPTH-1);
    rd("R1 zero read", 0);
    idle("R1 flush");
    // R7: oe low only in the first read's slot
    rd("R7 masked", 5);
    rd("R7 passes", 9);
    rd("R7 oe low", 0, 1'b0);
    rd("R7 oe back", 5, 1'b1);
    idle("R7 flush");
    idle("R7 flush");
    // R8: sleep with write and read attempts
    drive("R8 sleep wr", 1, 0, 1, 4'hF, 5, 32'hFFFF_FFFF, 1, 1);
    drive("R8 sleep wr2", 1, 1, 0, 4'hF, 9, 32'h0, 1, 1);
    drive("R8 sleep rd", 1, 0, 0, 4'h0, 9, 32'h0, 1, 1);
    idle("R8 wake");
    rd("R8 kept 5", 5);
    rd("R8 kept 9", 9);
    repeat (4) idle("flush");
    wait (sb.size() == 0);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule